// File: doc/BRIEF.md
# Strap-Sensing Shared LED Pin Controller

This block owns five bidirectional pads that do two jobs. Right after reset each pad is left undriven, so that an external pull resistor sets its level, and the controller reads that level as one bit of a five-bit PHY address. Once a settling window has run out, the sampled bits are frozen and published as the address. From then on the same pads drive status LEDs.

The drive polarity of each pad comes from its own strap. A pad that was pulled low lights its LED by driving high. A pad that was pulled high lights its LED by driving low. Because of this, the LED never fights the strap resistor's resting level. The status requests come from elsewhere in the chip. Pad electrical behaviour is outside this block.

The window length is the parameter `SETTLE_CYCLES`. Reset is synchronous and active high.

Top module: `shared_led_pins`

## Requirements
- R1: While `rst` is high, and until `addr_valid` is set, every bit of `pin_oe` and `pin_out` is 0.
- R2: `addr_valid` rises on exactly the `SETTLE_CYCLES`-th rising clock edge at which `rst` is low after a reset.
- R3: The strap bits are taken from `pin_in` at that last edge of the window only. Levels that `pin_in` held earlier in the window have no effect on the address.
- R4: `phy_addr[i]` equals the strap level sampled on pad i, with pad 0 as the least significant bit. It keeps that value, whatever `pin_in` does later, until the next reset.
- R5: A pad strapped 0 is active high: once `addr_valid` is set, `pin_out[i]` equals `led_req[i]`.
- R6: A pad strapped 1 is active low: once `addr_valid` is set, `pin_out[i]` equals the inverse of `led_req[i]`.
- R7: Once `addr_valid` is set, all five `pin_oe` bits are 1, and `addr_valid` stays set until the next reset.
- R8: A change on `led_req` appears on `pin_out` before the next rising clock edge.
- R9: Asserting `rst` at any time clears `addr_valid`, releases all pads on the following edge, and restarts the settling window, which then samples a fresh strap.
- R10: `led_req` has no effect on `pin_out` or `pin_oe` before `addr_valid` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| led_req | input | NUM_PINS | Status request per LED, 1 = lit |
| pin_in | input | NUM_PINS | Level read back from each pad |
| pin_oe | output | NUM_PINS | Pad output enable, 1 = driving |
| pin_out | output | NUM_PINS | Level driven onto each pad |
| phy_addr | output | NUM_PINS | Latched strap bits, pad 0 = LSB |
| addr_valid | output | 1 | Strap sampling complete |

## Verification
The hardest case to reach is a pad level that changes inside the settling window. The address must reflect only the value present at the final edge. To create this, the bench holds one strap pattern on `pin_in` through the early window. It switches to a different pattern one cycle before the window closes, then checks that only the late pattern is latched. A second reset taken in the middle of LED operation, with yet another pattern, confirms that the window restarts and that the polarity follows the new strap.

// File: rtl/shared_led_pkg.sv
package shared_led_pkg;

    localparam int DEF_PINS   = 5;
    localparam int DEF_SETTLE = 16;

    typedef enum logic {
        PH_SETTLE = 1'b0,
        PH_RUN    = 1'b1
    } phase_t;

    // Pad level for a lit/unlit request given the strap read on that pad.
    function automatic logic drive_level(input logic req, input logic strap);
        return req ^ strap;
    endfunction

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYCLES = shared_led_pkg::DEF_SETTLE
) (
    input  logic clk,
    input  logic rst,
    output logic sample_now
);
    import shared_led_pkg::*;

    localparam int CW = (SETTLE_CYCLES < 2) ? 1 : $clog2(SETTLE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;

    assign sample_now = (phase == PH_SETTLE) && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
        end else if (phase == PH_SETTLE) begin
            if (cnt == LAST) begin
                phase <= PH_RUN;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
    parameter int NUM_PINS = shared_led_pkg::DEF_PINS
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_now,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] strap,
    output logic                valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            strap <= '0;
            valid <= 1'b0;
        end else if (sample_now) begin
            strap <= pin_in;
            valid <= 1'b1;
        end
    end

endmodule

// File: rtl/led_polarity.sv
module led_polarity #(
    parameter int NUM_PINS = shared_led_pkg::DEF_PINS
) (
    input  logic                valid,
    input  logic [NUM_PINS-1:0] strap,
    input  logic [NUM_PINS-1:0] led_req,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out
);
    import shared_led_pkg::*;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pad
        assign pin_oe[i]  = valid;
        assign pin_out[i] = valid & drive_level(led_req[i], strap[i]);
    end

endmodule

// File: rtl/shared_led_pins.sv
module shared_led_pins #(
    parameter int NUM_PINS      = shared_led_pkg::DEF_PINS,
    parameter int SETTLE_CYCLES = shared_led_pkg::DEF_SETTLE
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] led_req,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] phy_addr,
    output logic                addr_valid
);

    logic                sample_now;
    logic [NUM_PINS-1:0] strap;
    logic                valid;

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_timer (
        .clk        (clk),
        .rst        (rst),
        .sample_now (sample_now)
    );

    strap_latch #(.NUM_PINS(NUM_PINS)) u_latch (
        .clk        (clk),
        .rst        (rst),
        .sample_now (sample_now),
        .pin_in     (pin_in),
        .strap      (strap),
        .valid      (valid)
    );

    led_polarity #(.NUM_PINS(NUM_PINS)) u_drive (
        .valid   (valid),
        .strap   (strap),
        .led_req (led_req),
        .pin_oe  (pin_oe),
        .pin_out (pin_out)
    );

    assign phy_addr   = strap;
    assign addr_valid = valid;

endmodule

// File: rtl/shared_led_chk.sv
module shared_led_chk #(
    parameter int NUM_PINS      = shared_led_pkg::DEF_PINS,
    parameter int SETTLE_CYCLES = shared_led_pkg::DEF_SETTLE
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] led_req,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] phy_addr,
    input logic                addr_valid
);

    localparam int KW = $clog2(SETTLE_CYCLES + 1);

    logic [KW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= '0;
        end else if (since_rst < KW'(SETTLE_CYCLES)) begin
            since_rst <= since_rst + 1'b1;
        end
    end

    AST_IDLE_UNTIL_VALID: assert property (@(posedge clk) disable iff (rst)
        !addr_valid |-> (pin_oe == '0 && pin_out == '0)); // R1
    AST_WINDOW_LENGTH: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_valid) |-> (since_rst == KW'(SETTLE_CYCLES))); // R2
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> $stable(phy_addr)); // R4
    AST_POLARITY: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (pin_out == (led_req ^ phy_addr))); // R5
    AST_ALL_DRIVING: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> (pin_oe == '1)); // R7
    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        addr_valid |=> addr_valid); // R7
    AST_RESET_RELEASE: assert property (@(posedge clk)
        rst |=> (!addr_valid && pin_oe == '0)); // R9

endmodule

bind shared_led_pins shared_led_chk #(
    .NUM_PINS      (NUM_PINS),
    .SETTLE_CYCLES (SETTLE_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .led_req    (led_req),
    .pin_oe     (pin_oe),
    .pin_out    (pin_out),
    .phy_addr   (phy_addr),
    .addr_valid (addr_valid)
);

// File: tb/shared_led_pins_test.sv
module shared_led_pins_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP         = 5;
    localparam int SETTLE     = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] led_req = '0;
    logic [NP-1:0] pin_in  = '0;
    logic [NP-1:0] pin_oe, pin_out, phy_addr;
    logic          addr_valid;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shared_led_pins #(.NUM_PINS(NP), .SETTLE_CYCLES(SETTLE)) uut (
        .clk        (clk),
        .rst        (rst),
        .led_req    (led_req),
        .pin_in     (pin_in),
        .pin_oe     (pin_oe),
        .pin_out    (pin_out),
        .phy_addr   (phy_addr),
        .addr_valid (addr_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reset, hold `early` through the window, switch to `late` one cycle
    // before the final edge; check idle pads and window length on the way.
    task automatic bring_up(input logic [NP-1:0] early, input logic [NP-1:0] late);
        @(negedge clk);
        rst = 1'b1;
        pin_in = early;
        repeat (3) @(negedge clk);
        check(pin_oe == '0 && pin_out == '0 && !addr_valid, "R1",
              {pin_oe, pin_out}, 0);
        rst = 1'b0;
        for (int c = 1; c < SETTLE; c++) begin
            @(negedge clk);
            led_req = 5'(c);                                  // R10 stimulus
            if (c == SETTLE - 1) pin_in = late;
            if (addr_valid || pin_oe != '0 || pin_out != '0)
                check(1'b0, "R2/R10 idle in window", {addr_valid, pin_oe, pin_out}, 0);
        end
        check(!addr_valid, "R2 not valid one edge early", addr_valid, 0);
        @(negedge clk);
        check(addr_valid, "R2 valid after window", addr_valid, 1);
        check(phy_addr == late, "R3 late strap latched", phy_addr, late);
        check(pin_oe == '1, "R7 all pads driving", pin_oe, 5'h1f);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(!addr_valid && pin_oe == '0 && pin_out == '0, "R1 reset state",
              {addr_valid, pin_oe, pin_out}, 0);
    endtask

    task automatic t_polarity(input logic [NP-1:0] strap);
        for (int r = 0; r < 32; r++) begin
            led_req = 5'(r);
            #1;
            check(pin_out == (5'(r) ^ strap), "R5/R6 polarity", pin_out, 5'(r) ^ strap);
            @(negedge clk);
        end
        for (int i = 0; i < NP; i++) begin
            led_req = '0;
            led_req[i] = 1'b1;
            #1;
            if (strap[i]) check(pin_out[i] == 1'b0, "R6 active-low pad", pin_out[i], 0);
            else          check(pin_out[i] == 1'b1, "R5 active-high pad", pin_out[i], 1);
        end
    endtask

    task automatic t_fast_update();
        @(negedge clk);
        led_req = 5'b00000;
        #1;
        check(pin_out == phy_addr, "R8 before change", pin_out, phy_addr);
        led_req = 5'b11111;
        #1;
        check(pin_out == ~phy_addr, "R8 change seen before next edge", pin_out, ~phy_addr);
    endtask

    task automatic t_addr_hold(input logic [NP-1:0] strap);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            pin_in = 5'(k * 7);
        end
        @(negedge clk);
        check(phy_addr == strap, "R4 address held", phy_addr, strap);
        check(addr_valid, "R7 valid stays set", addr_valid, 1);
    endtask

    task automatic t_midrun_reset();
        @(negedge clk);
        led_req = '1;
        rst = 1'b1;
        @(negedge clk);
        check(!addr_valid && pin_oe == '0 && pin_out == '0, "R9 reset releases pads",
              {addr_valid, pin_oe, pin_out}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!addr_valid, "R9 window restarted", addr_valid, 0);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset_state();
        bring_up(5'b01101, 5'b10110);
        t_polarity(5'b10110);
        t_fast_update();
        t_addr_hold(5'b10110);
        t_midrun_reset();
        bring_up(5'b00000, 5'b01001);
        t_polarity(5'b01001);
        bring_up(5'b11111, 5'b00001);
        check(phy_addr[0] == 1'b1 && phy_addr[4:1] == 4'b0, "R4 pad 0 is LSB", phy_addr, 1);
        t_polarity(5'b00001);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule